// File: doc/BRIEF.md
# Buffered Pulse-Width Modulator with Fractional Duty Bits

This block produces one pulse-width modulated output with up to ten bits of duty resolution from an eight-bit timer. An input clock first passes a selectable prescaler (divide by 1, 4 or 16). A two-bit sub-count runs below the timer, and the timer advances each time that sub-count wraps. The ten-bit position `{timer, sub-count}` is the value the duty setting is compared against. The period ends on the timer step that follows the timer equalling the period register. On that step the timer returns to zero, the output goes high, and the duty setting is copied into a shadow register.

Software may rewrite the duty setting at any moment. Because only the shadow takes part in the comparison, a new value changes the waveform starting with the next period, and no period is ever cut short or stretched. Dropping the mode enable returns every counter, the shadow and the output latch to zero. A separate direction input selects whether the pin is driven.

Top module: `pwm_period_match`

## Requirements
- R1: The duty setting is the ten-bit value `{duty_hi, duty_lo}`, with `duty_hi` as bits 9..2. Within a period the output is high for exactly duty × P clocks, starting at the first clock of the period. P is the prescale factor.
- R2: One period lasts (period + 1) × 4 × P clocks, with P = 1 for `presc_sel` = 0, P = 4 for `presc_sel` = 1, and P = 16 for `presc_sel` = 2 or 3. High phases of consecutive periods begin exactly one period apart.
- R3: A change to `duty_hi`/`duty_lo` in the middle of a period leaves that period unchanged. The new value governs the next period.
- R4: When the duty value taken at a period start is zero, the output stays low for the whole period. This holds even when the previous period was high at its end.
- R5: When the duty value is at least 4 × (period + 1), the output stays high for the whole period.
- R6: While `pwm_en` is low, the output latch, shadow, timer, sub-count and prescaler are held at zero. After `pwm_en` rises, the output stays low for (period + 1) × 4 × P − 1 clocks, and the first high phase follows.
- R7: `pwm_oe` is high only when `pwm_en` is high and `pin_dir_in` is low. `pwm_o` is low whenever `pwm_oe` is low. Toggling `pin_dir_in` does not disturb the internal output latch.
- R8: While `rst_n` is low the output latch is cleared and `pwm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | Mode enable; low clears all state |
| pin_dir_in | input | 1 | Pin direction, 1 = input (not driven), 0 = output |
| period | input | 8 | Period register value |
| duty_hi | input | 8 | Upper eight bits of the duty setting |
| duty_lo | input | 2 | Lower two bits of the duty setting |
| presc_sel | input | 2 | Prescale select: 0 → 1, 1 → 4, 2/3 → 16 |
| pwm_o | output | 1 | PWM pin value |
| pwm_oe | output | 1 | Pin output enable |

## Verification
The hardest condition to reach is a duty rewrite that lands inside a period, followed by a check that the period still carries the old value. A second hard case is a zero duty that follows a period whose output was high at its end, so that set and clear collide on one edge. The stimulus works from the cycle of the enable edge. It derives every period boundary from that edge, writes each new duty half a period after a boundary, and measures the following whole period for its high-time prefix. The sequences alternate between full, zero, over-range and ordinary duties. One case uses the largest period with duty 1023, which exercises the top ten-bit position.

// File: rtl/pwm_period_match.sv
module pwm_period_match #(
  parameter int TW = 8,
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_en,
  input  logic          pin_dir_in,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] duty_hi,
  input  logic [FW-1:0] duty_lo,
  input  logic [1:0]    presc_sel,
  output logic          pwm_o,
  output logic          pwm_oe
);
  localparam int DW = TW + FW;

  logic [3:0]    pcnt;
  logic [3:0]    plim;
  logic [FW-1:0] sub;
  logic [TW-1:0] tmr;
  logic [DW-1:0] shd;
  logic          out_q;
  logic          tick, step, bnd, hit;
  logic [DW-1:0] duty_w;
  logic [DW:0]   pos_nx;

  assign plim   = (presc_sel == 2'd0) ? 4'd0 : (presc_sel == 2'd1) ? 4'd3 : 4'd15;
  assign tick   = (pcnt == plim);
  assign step   = tick && (&sub);
  assign bnd    = step && (tmr == period);
  assign duty_w = {duty_hi, duty_lo};
  assign pos_nx = {1'b0, tmr, sub} + 1'b1;
  assign hit    = tick && !bnd && (pos_nx == {1'b0, shd});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= '0;
      sub   <= '0;
      tmr   <= '0;
      shd   <= '0;
      out_q <= 1'b0;
    end else if (!pwm_en) begin
      pcnt  <= '0;
      sub   <= '0;
      tmr   <= '0;
      shd   <= '0;
      out_q <= 1'b0;
    end else begin
      pcnt <= tick ? 4'd0 : pcnt + 4'd1;
      if (tick) sub <= sub + 1'b1;
      if (step) tmr <= bnd ? '0 : tmr + 1'b1;
      if (bnd) begin
        shd   <= duty_w;
        out_q <= |duty_w;
      end else if (hit) begin
        out_q <= 1'b0;
      end
    end
  end

  assign pwm_oe = pwm_en && !pin_dir_in;
  assign pwm_o  = out_q && pwm_oe;
endmodule

module pwm_period_match_chk #(
  parameter int TW = 8,
  parameter int FW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_en,
  input logic             out_q,
  input logic             bnd,
  input logic [TW-1:0]    tmr,
  input logic [FW-1:0]    sub,
  input logic [TW+FW-1:0] shd,
  input logic [3:0]       pcnt,
  input logic [3:0]       plim
);
  // R1
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (tmr == '0 && sub == '0));
  // R2
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= plim);
  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_en) && !$past(bnd)) |-> $stable(shd));
  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd == '0) |-> !out_q);
  // R6
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !out_q);
endmodule

bind pwm_period_match pwm_period_match_chk #(.TW(TW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .out_q(out_q), .bnd(bnd),
  .tmr(tmr), .sub(sub), .shd(shd), .pcnt(pcnt), .plim(plim)
);

// File: tb/tb_pwm_period_match.sv
module tb_pwm_period_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_en = 1'b0;
  logic pin_dir_in = 1'b0;
  logic [7:0] period = '0;
  logic [7:0] duty_hi = '0;
  logic [1:0] duty_lo = '0;
  logic [1:0] presc_sel = '0;
  logic pwm_o, pwm_oe;

  always #4 clk = ~clk;

  pwm_period_match dut (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .pin_dir_in(pin_dir_in),
    .period(period), .duty_hi(duty_hi), .duty_lo(duty_lo),
    .presc_sel(presc_sel), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int dv[8];
  int nd, L, P, PR;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  function automatic int exp_high(input int d);
    return (d >= 4 * (PR + 1)) ? L : d * P;
  endfunction

  task automatic drive_case();
    repeat (L - 1 + L / 2) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      exp_q.push_back(exp_high(dv[i]));
      if (i + 1 < nd) set_duty(dv[i + 1]);
      repeat (L) @(negedge clk);
    end
  endtask

  task automatic mon_case();
    int lows = 0;
    repeat (L - 1) begin
      @(negedge clk);
      if (!pwm_o) lows++;
    end
    chk(lows == L - 1, "R6 first period low", lows, L - 1);
    for (int w = 0; w < nd; w++) begin
      int hi = 0;
      int pre = 0;
      bit run = 1'b1;
      int e;
      string tag;
      repeat (L) begin
        @(negedge clk);
        if (pwm_o) hi++;
        if (pwm_o && run) pre++;
        else run = 1'b0;
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 scoreboard empty", 0, 1);
      end else begin
        e = exp_q.pop_front();
        tag = (e == 0) ? "R4 high time" : (e == L) ? "R5 high time" :
              (w > 0) ? "R3 high time" : "R1 high time";
        chk(hi == e, tag, hi, e);
        chk(pre == e, "R2 aligned prefix", pre, e);
      end
    end
  endtask

  task automatic run_case(input int pr, input int ps);
    @(negedge clk);
    pwm_en = 1'b0;
    @(negedge clk);
    PR = pr;
    P = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
    L = (pr + 1) * 4 * P;
    period = 8'(pr);
    presc_sel = 2'(ps);
    set_duty(dv[0]);
    pwm_en = 1'b1;
    fork
      drive_case();
      mon_case();
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pwm_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R8 output in reset", pwm_o, 0);
    pwm_en = 1'b0;
    #1;
    chk(pwm_oe == 1'b0, "R7 oe while disabled", pwm_oe, 0);
    rst_n = 1'b1;

    dv = '{5, 16, 0, 20, 1, 15, 0, 0}; nd = 6;
    run_case(3, 0);

    begin
      int k = 0;
      while (!pwm_o && k < 40) begin
        @(negedge clk);
        k++;
      end
    end
    chk(pwm_o == 1'b1, "R1 output reached high", pwm_o, 1);
    pin_dir_in = 1'b1;
    #1;
    chk(pwm_o == 1'b0, "R7 pin released", pwm_o, 0);
    chk(pwm_oe == 1'b0, "R7 oe low", pwm_oe, 0);
    pin_dir_in = 1'b0;
    #1;
    chk(pwm_oe == 1'b1, "R7 oe back", pwm_oe, 1);
    chk(pwm_o == 1'b1, "R7 latch kept", pwm_o, 1);
    pwm_en = 1'b0;
    @(negedge clk);
    chk(pwm_o == 1'b0, "R6 disabled low", pwm_o, 0);
    pwm_en = 1'b1;
    @(negedge clk);
    chk(pwm_o == 1'b0, "R6 latch cleared", pwm_o, 0);

    dv = '{13, 40, 0, 7, 60, 0, 0, 0}; nd = 5;
    run_case(9, 1);
    dv = '{6, 11, 3, 0, 0, 0, 0, 0}; nd = 3;
    run_case(2, 2);
    dv = '{1, 2, 3, 4, 0, 3, 0, 0}; nd = 6;
    run_case(0, 0);
    dv = '{1023, 512, 0, 0, 0, 0, 0, 0}; nd = 2;
    run_case(255, 0);
    dv = '{2, 9, 0, 0, 0, 0, 0, 0}; nd = 2;
    run_case(1, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule